// File: doc/BRIEF.md
# Configurable Output Line Controller

This block drives eight output pins from two 8-bit registers: a mode register that gives each programmable line its function, and a level register whose bits set, arm or gate the lines. Both registers are loaded through a one-cycle write port and can be read back through a combinational read port.

Lines 0 to 3 are either plain outputs that drive the inverse of their level bit, or chip selects. A chip select is low during a bus cycle when its level bit is set. Lines 4 and 5 are either plain inverting outputs or strobes. A strobe rests high, pulses low for a fixed number of clocks when a 1 is written to its bit, and then clears that bit by itself. Line 6 can be a plain output, a strobe, or an auto-power pin that follows an external power-off request. Bit 7 of the level register is a bus reset bit, driven on two pins of opposite polarity.

Top module: `out_line_ctrl`

## Requirements
- R1: After reset both registers read 0x00, lines 0-6 are high, `bus_rst_o` is 0 and `bus_rst_n_o` is 1.
- R2: When mode bit N (N = 0..3) is 1, line N is low exactly when `bus_cycle_i` is 1 and level bit N is 1. Otherwise line N is high.
- R3: A line in plain output mode drives the inverse of its level bit. This applies to lines 0-3 with mode bit N = 0, lines 4 and 5 with mode bit 4 or 5 = 0, and line 6 with mode bits [7:6] = 2'b01.
- R4: Mode bit 4 (line 4) and mode bit 5 (line 5) select strobe mode when 1. Line 6 is decoded from mode bits [7:6]: x0 gives auto-power, 01 gives plain output, 11 gives strobe.
- R5: A strobe-mode line rests high. Writing a 1 to its level bit drives it low for exactly STB_CYCLES (default 2) clocks, starting in the cycle after the write. The level bit reads 1 during the pulse and reads 0 once the pulse ends.
- R6: Writing a 1 to a strobe bit while its pulse is running restarts the full STB_CYCLES pulse from that write.
- R7: In auto-power mode, line 6 is low exactly when `pwr_off_req_i` is 1.
- R8: `bus_rst_o` equals level bit 7 and `bus_rst_n_o` is its inverse, in every line mode.
- R9: A write with `wr_sel_i` = 0 loads the mode register and a write with `wr_sel_i` = 1 loads the level register, at the clock edge where `wr_en_i` is 1. `rd_data_o` shows the mode register when `rd_sel_i` = 0 and the level register when `rd_sel_i` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 selects the mode register, 1 selects the level register |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read target: 0 selects the mode register, 1 selects the level register |
| rd_data_o | output | 8 | Read data |
| bus_cycle_i | input | 1 | High while a peripheral bus cycle is in progress |
| pwr_off_req_i | input | 1 | Request to remove power; used by line 6 in auto-power mode |
| line_n_o | output | 7 | Programmable output lines 0-6 |
| bus_rst_o | output | 1 | Bus reset, active high |
| bus_rst_n_o | output | 1 | Bus reset, active low |

## Verification
The assertions check four things on every cycle: that chip selects stay high outside bus cycles, that an armed strobe stays low in the clock after its falling edge, that the auto-power pin follows the request, and that the two reset pins stay complementary. Several behaviours can only be shown by the bench scenarios. These are the exact pulse length and the self-clearing of the strobe bit seen on readback, the restart of a pulse that is already running, the full decode of line 6 across all four values of mode bits [7:6], and the write-then-read timing. The bench covers them by comparing a behavioural model against every pin on every clock.

// File: rtl/olc_pkg.sv
package olc_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_PROG  = 7;
  localparam int NUM_CSEL  = 4;
  localparam int APWR_LINE = 6;

  typedef enum logic [1:0] {
    LM_GPIO = 2'd0,
    LM_CSEL = 2'd1,
    LM_STRB = 2'd2,
    LM_APWR = 2'd3
  } line_mode_e;
endpackage

// File: rtl/olc_mode_dec.sv
module olc_mode_dec
  import olc_pkg::*;
(
  input  logic [REG_W-1:0] cfg_i,
  output line_mode_e       mode_o [NUM_PROG]
);
  for (genvar i = 0; i < NUM_PROG; i++) begin : g_dec
    if (i < NUM_CSEL) begin : g_cs
      assign mode_o[i] = cfg_i[i] ? LM_CSEL : LM_GPIO;
    end else if (i < APWR_LINE) begin : g_stb
      assign mode_o[i] = cfg_i[i] ? LM_STRB : LM_GPIO;
    end else begin : g_l6
      // bit 6 clear: auto-power, bit 7 picks strobe over plain output
      assign mode_o[i] = !cfg_i[6] ? LM_APWR : (cfg_i[7] ? LM_STRB : LM_GPIO);
    end
  end
endmodule

// File: rtl/olc_strobe.sv
module olc_strobe #(
  parameter int STB_CYCLES = 2,
  localparam int CNT_W     = $clog2(STB_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic active_o,
  output logic last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (fire_i)         cnt_q <= CNT_W'(STB_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
  assign last_o   = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/olc_regs.sv
module olc_regs
  import olc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [REG_W-1:0] self_clr_i,
  output logic [REG_W-1:0] cfg_o,
  output logic [REG_W-1:0] lvl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
      lvl_o <= '0;
    end else begin
      if (wr_en_i && !wr_sel_i) cfg_o <= wr_data_i;
      if (wr_en_i && wr_sel_i)  lvl_o <= wr_data_i;
      else                      lvl_o <= lvl_o & ~self_clr_i;
    end
  end
endmodule

// File: rtl/out_line_ctrl.sv
module out_line_ctrl
  import olc_pkg::*;
#(
  parameter int STB_CYCLES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_sel_i,
  input  logic [REG_W-1:0]    wr_data_i,
  input  logic                rd_sel_i,
  output logic [REG_W-1:0]    rd_data_o,
  input  logic                bus_cycle_i,
  input  logic                pwr_off_req_i,
  output logic [NUM_PROG-1:0] line_n_o,
  output logic                bus_rst_o,
  output logic                bus_rst_n_o
);
  logic [REG_W-1:0]    cfg_q, lvl_q, self_clr;
  line_mode_e          mode [NUM_PROG];
  logic [NUM_PROG-1:0] stb_active, stb_last;

  olc_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .self_clr_i(self_clr), .cfg_o(cfg_q), .lvl_o(lvl_q)
  );

  olc_mode_dec u_dec (.cfg_i(cfg_q), .mode_o(mode));

  assign self_clr[REG_W-1] = 1'b0;

  for (genvar i = 0; i < NUM_PROG; i++) begin : g_line
    if (i < NUM_CSEL) begin : g_cs
      assign stb_active[i] = 1'b0;
      assign stb_last[i]   = 1'b0;
      assign self_clr[i]   = 1'b0;
      assign line_n_o[i]   = (mode[i] == LM_CSEL) ? ~(bus_cycle_i & lvl_q[i]) : ~lvl_q[i];
    end else begin : g_st
      logic fire;
      assign fire = wr_en_i && wr_sel_i && wr_data_i[i] && (mode[i] == LM_STRB);
      olc_strobe #(.STB_CYCLES(STB_CYCLES)) u_stb (
        .clk_i, .rst_ni, .fire_i(fire),
        .active_o(stb_active[i]), .last_o(stb_last[i])
      );
      assign self_clr[i] = (mode[i] == LM_STRB) && stb_last[i];
      always_comb begin
        unique case (mode[i])
          LM_STRB: line_n_o[i] = ~stb_active[i];
          LM_APWR: line_n_o[i] = ~pwr_off_req_i;
          default: line_n_o[i] = ~lvl_q[i];
        endcase
      end
    end
  end

  assign bus_rst_o   = lvl_q[REG_W-1];
  assign bus_rst_n_o = ~lvl_q[REG_W-1];
  assign rd_data_o   = rd_sel_i ? lvl_q : cfg_q;
endmodule

// File: rtl/olc_checker.sv
module olc_checker
  import olc_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bus_cycle_i,
  input logic                pwr_off_req_i,
  input logic [REG_W-1:0]    cfg_q,
  input logic [NUM_PROG-1:0] line_n_o,
  input logic                bus_rst_o,
  input logic                bus_rst_n_o
);
  for (genvar i = 0; i < NUM_CSEL; i++) begin : g_cs
    assert_cs_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q[i] && !bus_cycle_i) |-> line_n_o[i]);
  end

  assert_strobe_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[4] && $fell(line_n_o[4])) |=> (!cfg_q[4] || !line_n_o[4]));

  assert_autopwr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q[6] |-> (line_n_o[6] == !pwr_off_req_i));

  assert_rst_pair_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_o != bus_rst_n_o);
endmodule

bind out_line_ctrl olc_checker u_olc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_cycle_i(bus_cycle_i),
  .pwr_off_req_i(pwr_off_req_i), .cfg_q(cfg_q), .line_n_o(line_n_o),
  .bus_rst_o(bus_rst_o), .bus_rst_n_o(bus_rst_n_o)
);

// File: tb/tb_out_line_ctrl.sv
module tb_out_line_ctrl;
  localparam int STB = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0, bus_cyc = 0, pwr_off = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic [6:0] line_n;
  logic bus_rst, bus_rst_n;

  int vectors = 0, errors = 0, cycles = 0;
  int m_cfg = 0, m_lvl = 0;
  int m_cnt [7];

  always #10 clk = ~clk;

  out_line_ctrl #(.STB_CYCLES(STB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .bus_cycle_i(bus_cyc), .pwr_off_req_i(pwr_off), .line_n_o(line_n),
    .bus_rst_o(bus_rst), .bus_rst_n_o(bus_rst_n)
  );

  // model: 0 plain, 1 chip select, 2 strobe, 3 auto-power
  function automatic int mode_of(int n);
    if (n < 4) return ((m_cfg >> n) & 1) ? 1 : 0;
    if (n < 6) return ((m_cfg >> n) & 1) ? 2 : 0;
    if (((m_cfg >> 6) & 1) == 0) return 3;
    return ((m_cfg >> 7) & 1) ? 2 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0t act=%0h exp=%0h", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cfg = 0; m_lvl = 0;
      for (int i = 0; i < 7; i++) m_cnt[i] = 0;
    end else begin
      int old_cfg;
      old_cfg = m_cfg;
      for (int i = 4; i < 7; i++) begin
        bit is_stb, fire;
        is_stb = (mode_of(i) == 2);
        fire = wr_en && wr_sel && wr_data[i] && is_stb;
        if (!(wr_en && wr_sel) && is_stb && m_cnt[i] <= 1) m_lvl &= ~(1 << i);
        if (fire) m_cnt[i] = STB;
        else if (m_cnt[i] > 0) m_cnt[i]--;
      end
      if (wr_en && wr_sel) m_lvl = wr_data;
      if (wr_en && !wr_sel) m_cfg = wr_data;
      if (old_cfg != m_cfg) ;
    end
    #5;
    if (rst_n) begin
      for (int i = 0; i < 7; i++) begin
        int md, exp;
        md = mode_of(i);
        case (md)
          1: exp = !(bus_cyc && ((m_lvl >> i) & 1));
          2: exp = (m_cnt[i] == 0);
          3: exp = !pwr_off;
          default: exp = !((m_lvl >> i) & 1);
        endcase
        case (md)
          1: check("R2 chip select", line_n[i], exp);
          2: check("R5 strobe line", line_n[i], exp);
          3: check("R7 auto-power", line_n[i], exp);
          default: check("R3 plain output", line_n[i], exp);
        endcase
      end
      check("R8 bus reset", bus_rst, (m_lvl >> 7) & 1);
      check("R8 bus reset n", bus_rst_n, !((m_lvl >> 7) & 1));
      check("R9 readback", rd_data, rd_sel ? m_lvl : m_cfg);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      rd_sel = ~rd_sel;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 lines", line_n, 7'h7f);
    check("R1 bus_rst", {bus_rst, bus_rst_n}, 2'b01);
    check("R1 cfg", rd_data, 0);
    rst_n = 1;
    idle(2);
    // R3 plain outputs on every line (line 6 via mode 2'b01)
    wr(0, 8'h40);
    wr(1, 8'h55); idle(2);
    wr(1, 8'h2a); idle(2);
    // R2 chip selects gated by bus cycle
    wr(0, 8'h4f);
    wr(1, 8'h05);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); bus_cyc = k[0];
    end
    wr(1, 8'h0f); bus_cyc = 1; idle(2); bus_cyc = 0; idle(1);
    // R4 R5 strobes on lines 4..6
    wr(0, 8'hf0);
    wr(1, 8'h70); idle(4);
    wr(1, 8'h10); idle(1);
    // R6 restart mid-pulse
    wr(1, 8'h20);
    @(negedge clk); wr_en = 1; wr_sel = 1; wr_data = 8'h20;
    @(negedge clk); wr_en = 0; idle(4);
    // R7 auto-power with line 6 mode x0 (both values of bit 7)
    wr(0, 8'h30);
    pwr_off = 1; idle(2); pwr_off = 0; idle(2);
    wr(0, 8'hb0);
    pwr_off = 1; idle(2); pwr_off = 0; idle(1);
    // R8 reset bit in any mode
    wr(1, 8'h80); idle(2);
    wr(1, 8'h00); idle(2);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule